// File: doc/BRIEF.md
# UART FIFO Register Front-End

This block is the processor-facing half of a UART. It holds a transmit byte queue and a receive byte queue and exposes them, together with status, queue flags, occupancy counters, a stored baud divisor, a modem control byte and a soft-reset key, through a small map of 32-bit registers. The processor port is synchronous: a write takes effect at the clock edge where it is presented, and a read returns its data on `bus_rdata` one cycle later, with any side effect of the read applied at that same edge.

The line side is a plain byte stream. A one-cycle burst request starts a drain: the block then presents one transmit byte per cycle on `line_tx_byte` with `line_tx_valid` high, each of which counts as taken. A burst ends after `BURST_MAX` bytes or as soon as the transmit queue is found empty. Received bytes arrive one per cycle on a push strobe. Serial framing, parity and bit timing live elsewhere; the divisor is only stored for that logic. The interrupt output is a level, gated by a modem-control enable bit.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset the status register reads 0x40, the queue flag register reads 0x11, modem control, divisor, both counters and the key register read 0, `irq` is 0, `line_tx_valid` is 0 and `bus_rdata` is 0.
- R2: Word offsets (byte offset / 4): 0 data, 1 control write / status read, 2 modem control, 3 divisor, 4 queue flags, 5 transmit count, 6 receive count, 8 key register. A read presented in cycle N appears on `bus_rdata` after edge N and is held until the next read. Reads of any other offset return 0; writes to them change nothing visible.
- R3: A status read returns the value held before the edge and clears status bit7 (receive event) and bit5 (transmit done); an event that sets either bit in the same cycle wins over the clear.
- R4: `irq` is high exactly while modem-control bit2 is 1 and at least one of status bits 7, 5, 3, 2, 1, 0 is 1.
- R5: Writing a value whose low byte is 0x55 to offset 8 empties both queues, ends any burst, sets status to 0x40, queue flags to 0x11, control, modem control, divisor and key register to 0, and re-enables reception; any other value is stored and read back from offset 8.
- R6: A write to offset 0 appends its low byte to the transmit queue when it holds fewer than TX_DEPTH bytes, clearing queue flag bit0 and status bit6; when full the byte is dropped and queue flag bit2 is set.
- R7: A transmit pop after which the queue is empty sets queue flag bit0, clears queue flag bits 3..1 and sets status bits 6 and 5. Queue flag bits 1, 3, 5 and 7 are never set by this block.
- R8: A burst request while idle starts a drain at the next edge; bytes leave in order, one per cycle, at most BURST_MAX (128) per burst, stopping once the queue is empty; a request during a burst is ignored and a request on an empty queue yields no byte.
- R9: Every receive push strobe sets status bit7; when reception is enabled and fewer than RX_DEPTH bytes are held the byte is queued and queue flag bit4 is cleared; a push into a full queue is dropped and sets queue flag bit6.
- R10: A read of offset 0 returns the oldest received byte and removes it, or returns 0 when the queue is empty; a data read after which the queue is empty sets queue flag bit4 and clears status bit2.
- R11: A divisor write stores the low 16 bits when the full 32-bit write value is non-zero; a write of zero leaves the divisor unchanged.
- R12: A modem-control write with bit5 clear disables reception, and it stays disabled through later modem-control writes until a soft reset; a disabled push changes no count but still sets status bit7.
- R13: Offsets 5 and 6 return the current number of bytes held in the transmit and receive queues, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when `bus_wr` is high) |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| line_rx_push | input | 1 | Received byte strobe |
| line_rx_byte | input | 8 | Received byte |
| line_tx_burst | input | 1 | Burst drain request |
| line_tx_valid | output | 1 | A transmit byte is taken this cycle |
| line_tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The status register can be cleared by a processor read in the very cycle a line-side event sets one of its cleared bits: a received byte sets bit7, and a drain that empties the transmit queue sets bit5. The bench provokes both collisions by issuing the status read in the same cycle as a receive push, and in the cycle a one-byte burst takes its last byte. It judges them by the value returned (the pre-edge status) and by the following status read and `irq`, which must still show the newly set bit.

// File: rtl/uart_fifo_regs_pkg.sv
package uart_fifo_regs_pkg;

    // Word offsets of the register map
    localparam int W_DATA   = 0;
    localparam int W_CSTAT  = 1;
    localparam int W_MODEM  = 2;
    localparam int W_DIV    = 3;
    localparam int W_FLAGS  = 4;
    localparam int W_TXCNT  = 5;
    localparam int W_RXCNT  = 6;
    localparam int W_KEY    = 8;

    // Status register bit positions
    localparam int ST_OVR    = 2;
    localparam int ST_TDONE  = 5;
    localparam int ST_TEMPTY = 6;
    localparam int ST_RXEVT  = 7;

    // Queue flag register bit positions
    localparam int FL_TEMPTY = 0;
    localparam int FL_TFULL  = 2;
    localparam int FL_REMPTY = 4;
    localparam int FL_RFULL  = 6;

    // Modem control bit positions
    localparam int MC_IEN  = 2;
    localparam int MC_RXEN = 5;

    localparam logic [7:0] SOFT_KEY   = 8'h55;
    localparam logic [7:0] STAT_INIT  = 8'h40;
    localparam logic [7:0] FLAGS_INIT = 8'h11;
    localparam logic [7:0] IRQ_SRC    = 8'hAF;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) begin
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (pop) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[st_q.wr] <= push_data;
        end
    end

    assign head  = mem[st_q.rd];
    assign count = st_q.cnt;

endmodule

// File: rtl/uart_tx_burst.sv
module uart_tx_burst #(
    parameter int BURST_MAX = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic req,
    input  logic avail,
    output logic pop
);

    localparam int LEFT_W = $clog2(BURST_MAX + 1);
    localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(BURST_MAX);

    typedef struct packed {
        logic              busy;
        logic [LEFT_W-1:0] left;
    } burst_st_t;

    burst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d = '0;
        end else if (st_q.busy) begin
            if (avail) begin
                st_d.left = st_q.left - 1'b1;
                st_d.busy = (st_q.left != LEFT_W'(1));
            end else begin
                st_d.busy = 1'b0;
                st_d.left = '0;
            end
        end else if (req) begin
            st_d.busy = 1'b1;
            st_d.left = LEFT_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop = st_q.busy && avail;

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
    import uart_fifo_regs_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int TX_DEPTH  = 2048,
    parameter int RX_DEPTH  = 1024,
    parameter int BURST_MAX = 128,
    parameter int DIV_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              line_rx_push,
    input  logic [7:0]        line_rx_byte,
    input  logic              line_tx_burst,
    output logic              line_tx_valid,
    output logic [7:0]        line_tx_byte,
    output logic              irq
);

    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam logic [TX_CW-1:0] TX_FULL = TX_CW'(TX_DEPTH);
    localparam logic [RX_CW-1:0] RX_FULL = RX_CW'(RX_DEPTH);

    typedef struct packed {
        logic [7:0]       stat;
        logic [7:0]       flags;
        logic [7:0]       ctrl;
        logic [7:0]       modem;
        logic [DIV_W-1:0] div;
        logic [7:0]       key;
        logic             rx_en;
        logic [31:0]      rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [TX_CW-1:0] tx_cnt;
    logic [RX_CW-1:0] rx_cnt;
    logic [7:0]       rx_head;
    logic [7:0]       tx_head;

    logic rd_eff, stat_rd, soft_rst;
    logic tx_push_req, tx_push_ok, tx_drop, tx_pop, tx_empty_evt;
    logic rx_rd, rx_pop, rx_push_ok, rx_drop, rx_left_empty;
    logic irq_en, rx_accept;
    logic [31:0] rd_val;

    // ------------------------------------------------------------------
    // Event decode from the pre-edge state
    // ------------------------------------------------------------------
    assign irq_en    = st_q.modem[MC_IEN];
    assign rx_accept = st_q.rx_en;

    assign rd_eff   = bus_rd && !bus_wr;
    assign stat_rd  = rd_eff && (bus_addr == ADDR_W'(W_CSTAT));
    assign soft_rst = bus_wr && (bus_addr == ADDR_W'(W_KEY))
                      && (bus_wdata[7:0] == SOFT_KEY);

    assign tx_push_req  = bus_wr && (bus_addr == ADDR_W'(W_DATA));
    assign tx_push_ok   = tx_push_req && (tx_cnt < TX_FULL);
    assign tx_drop      = tx_push_req && !tx_push_ok;
    assign tx_empty_evt = tx_pop && !tx_push_ok && (tx_cnt == TX_CW'(1));

    assign rx_rd         = rd_eff && (bus_addr == ADDR_W'(W_DATA));
    assign rx_pop        = rx_rd && (rx_cnt != '0);
    assign rx_push_ok    = line_rx_push && rx_accept && (rx_cnt < RX_FULL);
    assign rx_drop       = line_rx_push && rx_accept && (rx_cnt == RX_FULL);
    assign rx_left_empty = rx_rd && !rx_push_ok && (rx_cnt <= RX_CW'(1));

    // ------------------------------------------------------------------
    // Queues and burst drain
    // ------------------------------------------------------------------
    uart_byte_fifo #(.DEPTH(TX_DEPTH), .W(8)) tx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (tx_push_ok),
        .push_data (bus_wdata[7:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_cnt)
    );

    uart_byte_fifo #(.DEPTH(RX_DEPTH), .W(8)) rx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (rx_push_ok),
        .push_data (line_rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    uart_tx_burst #(.BURST_MAX(BURST_MAX)) burst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (soft_rst),
        .req   (line_tx_burst),
        .avail (tx_cnt != '0),
        .pop   (tx_pop)
    );

    // ------------------------------------------------------------------
    // Read multiplexer
    // ------------------------------------------------------------------
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            ADDR_W'(W_DATA):  rd_val = (rx_cnt != '0) ? 32'(rx_head) : '0;
            ADDR_W'(W_CSTAT): rd_val = 32'(st_q.stat);
            ADDR_W'(W_MODEM): rd_val = 32'(st_q.modem);
            ADDR_W'(W_DIV):   rd_val = 32'(st_q.div);
            ADDR_W'(W_FLAGS): rd_val = 32'(st_q.flags);
            ADDR_W'(W_TXCNT): rd_val = 32'(tx_cnt);
            ADDR_W'(W_RXCNT): rd_val = 32'(rx_cnt);
            ADDR_W'(W_KEY):   rd_val = 32'(st_q.key);
            default:          rd_val = '0;
        endcase
    end

    // ------------------------------------------------------------------
    // Next register state
    // ------------------------------------------------------------------
    always_comb begin
        st_d = st_q;

        if (rd_eff) begin
            st_d.rdata = rd_val;
        end

        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(W_CSTAT): st_d.ctrl = bus_wdata[7:0];
                ADDR_W'(W_MODEM): begin
                    st_d.modem = bus_wdata[7:0];
                    if (!bus_wdata[MC_RXEN]) begin
                        st_d.rx_en = 1'b0;
                    end
                end
                ADDR_W'(W_DIV): begin
                    if (|bus_wdata) begin
                        st_d.div = bus_wdata[DIV_W-1:0];
                    end
                end
                ADDR_W'(W_KEY):   st_d.key = bus_wdata[7:0];
                default:          ;
            endcase
        end

        // Clear-on-read first, so that set events below take priority
        if (stat_rd) begin
            st_d.stat[ST_RXEVT] = 1'b0;
            st_d.stat[ST_TDONE] = 1'b0;
        end

        if (tx_push_ok) begin
            st_d.flags[FL_TEMPTY] = 1'b0;
            st_d.stat[ST_TEMPTY]  = 1'b0;
        end
        if (tx_drop) begin
            st_d.flags[FL_TFULL] = 1'b1;
        end
        if (tx_empty_evt) begin
            st_d.flags[3:0]      = 4'b0001;
            st_d.stat[ST_TEMPTY] = 1'b1;
            st_d.stat[ST_TDONE]  = 1'b1;
        end

        if (line_rx_push) begin
            st_d.stat[ST_RXEVT] = 1'b1;
        end
        if (rx_push_ok) begin
            st_d.flags[FL_REMPTY] = 1'b0;
        end
        if (rx_drop) begin
            st_d.flags[FL_RFULL] = 1'b1;
        end
        if (rx_left_empty) begin
            st_d.flags[FL_REMPTY] = 1'b1;
            st_d.stat[ST_OVR]     = 1'b0;
        end

        if (soft_rst) begin
            st_d.stat  = STAT_INIT;
            st_d.flags = FLAGS_INIT;
            st_d.ctrl  = '0;
            st_d.modem = '0;
            st_d.div   = '0;
            st_d.key   = '0;
            st_d.rx_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.stat  <= STAT_INIT;
            st_q.flags <= FLAGS_INIT;
            st_q.rx_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata     = st_q.rdata;
    assign line_tx_valid = tx_pop;
    assign line_tx_byte  = tx_head;
    assign irq           = irq_en && ((st_q.stat & IRQ_SRC) != '0);

endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
    parameter int ADDR_W    = 4,
    parameter int TX_DEPTH  = 2048,
    parameter int RX_DEPTH  = 1024,
    parameter int BURST_MAX = 128,
    localparam int TX_CW = $clog2(TX_DEPTH + 1),
    localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              line_rx_push,
    input logic              line_tx_valid,
    input logic              irq,
    input logic              irq_en,
    input logic              rx_accept,
    input logic [TX_CW-1:0]  tx_cnt,
    input logic [RX_CW-1:0]  rx_cnt
);

    localparam int RUN_W = $clog2(BURST_MAX + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (line_tx_valid) begin
            if (run_q != '1) begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    logic key_wr, data_rd;
    assign key_wr  = bus_wr && (bus_addr == ADDR_W'(8)) && (bus_wdata[7:0] == 8'h55);
    assign data_rd = bus_rd && !bus_wr && (bus_addr == ADDR_W'(0));

    // R4: no interrupt while the enable bit is clear
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R5: soft reset empties queues and silences outputs
    a_r5_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (tx_cnt == '0) && (rx_cnt == '0) && !irq && !line_tx_valid);

    // R6: transmit occupancy never exceeds its depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_cnt) <= TX_DEPTH);

    // R9: receive occupancy never exceeds its depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_cnt) <= RX_DEPTH);

    // R8: a burst hands out at most BURST_MAX consecutive bytes
    a_r8_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_valid |-> (32'(run_q) < BURST_MAX));

    // R10: reading an empty receive queue returns zero
    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (rx_cnt == '0)) |=> (bus_rdata == '0));

    // R12: with reception disabled the count moves only through reads or reset
    a_r12_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_accept && line_rx_push && !data_rd && !key_wr) |=> $stable(rx_cnt));

endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(
    .ADDR_W    (ADDR_W),
    .TX_DEPTH  (TX_DEPTH),
    .RX_DEPTH  (RX_DEPTH),
    .BURST_MAX (BURST_MAX)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .line_rx_push  (line_rx_push),
    .line_tx_valid (line_tx_valid),
    .irq           (irq),
    .irq_en        (irq_en),
    .rx_accept     (rx_accept),
    .tx_cnt        (tx_cnt),
    .rx_cnt        (rx_cnt)
);

// File: tb/uart_fifo_regs_tb.sv
module uart_fifo_regs_tb_top;

    localparam int TXD   = 2048;
    localparam int RXD   = 1024;
    localparam int BURST = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_rx_push = 1'b0;
    logic [7:0]  line_rx_byte = '0;
    logic        line_tx_burst = 1'b0;
    logic        line_tx_valid;
    logic [7:0]  line_tx_byte;
    logic        irq;

    always #5 clk = ~clk;

    uart_fifo_regs dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .line_rx_push  (line_rx_push),
        .line_rx_byte  (line_rx_byte),
        .line_tx_burst (line_tx_burst),
        .line_tx_valid (line_tx_valid),
        .line_tx_byte  (line_tx_byte),
        .irq           (irq)
    );

    int    checks = 0;
    int    failures = 0;
    string phase = "R1";
    bit    done = 1'b0;

    // Behavioural reference model
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [7:0]  m_stat, m_flags, m_modem, m_key;
    logic [15:0] m_div;
    logic [31:0] m_rdata;
    bit          m_rxen, m_busy;
    int          m_left;

    task automatic model_regs_init();
        txq.delete();
        rxq.delete();
        m_stat  = 8'h40;
        m_flags = 8'h11;
        m_modem = '0;
        m_key   = '0;
        m_div   = '0;
        m_rxen  = 1'b1;
        m_busy  = 1'b0;
        m_left  = 0;
    endtask

    task automatic model_step();
        logic [31:0] rv;
        int  tsz, rsz;
        bit  rd_e, pop, push, push_ok, pe, rxrd, rxacc, rxdrop;
        tsz = txq.size();
        rsz = rxq.size();
        case (bus_addr)
            4'd0:    rv = (rsz > 0) ? 32'(rxq[0]) : 32'd0;
            4'd1:    rv = 32'(m_stat);
            4'd2:    rv = 32'(m_modem);
            4'd3:    rv = 32'(m_div);
            4'd4:    rv = 32'(m_flags);
            4'd5:    rv = 32'(tsz);
            4'd6:    rv = 32'(rsz);
            4'd8:    rv = 32'(m_key);
            default: rv = 32'd0;
        endcase
        rd_e = bus_rd && !bus_wr;
        if (rd_e) m_rdata = rv;
        if (bus_wr && bus_addr == 4'd8 && bus_wdata[7:0] == 8'h55) begin
            model_regs_init();
            return;
        end
        pop     = m_busy && (tsz > 0);
        push    = bus_wr && (bus_addr == 4'd0);
        push_ok = push && (tsz < TXD);
        pe      = pop && !push_ok && (tsz == 1);
        rxrd    = rd_e && (bus_addr == 4'd0);
        rxacc   = line_rx_push && m_rxen && (rsz < RXD);
        rxdrop  = line_rx_push && m_rxen && !(rsz < RXD);

        if (rd_e && bus_addr == 4'd1) m_stat = m_stat & 8'h5F;

        if (pop) void'(txq.pop_front());
        if (push_ok) txq.push_back(bus_wdata[7:0]);
        if (m_busy) begin
            if (tsz > 0) begin
                m_left = m_left - 1;
                m_busy = (m_left > 0);
            end else begin
                m_busy = 1'b0;
            end
        end else if (line_tx_burst) begin
            m_busy = 1'b1;
            m_left = BURST;
        end
        if (push_ok) begin
            m_flags[0] = 1'b0;
            m_stat[6]  = 1'b0;
        end
        if (push && !push_ok) m_flags[2] = 1'b1;
        if (pe) begin
            m_flags = (m_flags & 8'hF0) | 8'h01;
            m_stat  = m_stat | 8'h60;
        end

        if (rxrd && rsz > 0) void'(rxq.pop_front());
        if (rxacc) rxq.push_back(line_rx_byte);
        if (line_rx_push) m_stat[7] = 1'b1;
        if (rxacc) m_flags[4] = 1'b0;
        if (rxdrop) m_flags[6] = 1'b1;
        if (rxrd && !rxacc && rxq.size() == 0) begin
            m_flags[4] = 1'b1;
            m_stat[2]  = 1'b0;
        end

        if (bus_wr) begin
            case (bus_addr)
                4'd2: begin
                    m_modem = bus_wdata[7:0];
                    if (!bus_wdata[5]) m_rxen = 1'b0;
                end
                4'd3: if (bus_wdata != 32'd0) m_div = bus_wdata[15:0];
                4'd8: m_key = bus_wdata[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_irq, exp_valid;
        exp_irq   = m_modem[2] && ((m_stat & 8'hAF) != 8'h00);
        exp_valid = m_busy && (txq.size() > 0);
        chk(phase, "irq", 32'(irq), 32'(exp_irq));
        chk(phase, "tx_valid", 32'(line_tx_valid), 32'(exp_valid));
        if (exp_valid) chk(phase, "tx_byte", 32'(line_tx_byte), 32'(txq[0]));
        chk(phase, "rdata", bus_rdata, m_rdata);
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = 4'(a);
        step();
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_expect(input int a, input logic [31:0] exp, input string what);
        logic [31:0] v;
        rd_reg(a, v);
        chk(phase, what, v, exp);
    endtask

    task automatic rx_put(input logic [7:0] b);
        line_rx_push = 1'b1; line_rx_byte = b;
        step();
        line_rx_push = 1'b0;
    endtask

    task automatic burst(input int wait_cycles);
        line_tx_burst = 1'b1;
        step();
        line_tx_burst = 1'b0;
        repeat (wait_cycles) step();
    endtask

    initial begin
        #(1500000 * 1ns);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        model_regs_init();
        m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        phase = "R1";
        compare();
        rd_expect(1, 32'h40, "status");
        rd_expect(4, 32'h11, "flags");
        rd_expect(2, 32'h0, "modem");
        rd_expect(3, 32'h0, "divisor");
        rd_expect(5, 32'h0, "txcnt");
        rd_expect(6, 32'h0, "rxcnt");
        rd_expect(8, 32'h0, "key");

        // R2: unmapped offsets
        phase = "R2";
        wr_reg(7, 32'hFFFF_FFFF);
        wr_reg(9, 32'h1234_5678);
        rd_expect(7, 32'h0, "unmapped7");
        rd_expect(9, 32'h0, "unmapped9");
        rd_expect(12, 32'h0, "unmapped12");
        rd_expect(4, 32'h11, "flags after unmapped write");
        rd_expect(1, 32'h40, "status after unmapped write");

        // R11: divisor store, zero ignored
        phase = "R11";
        wr_reg(3, 32'h0000_1234);
        rd_expect(3, 32'h1234, "divisor");
        wr_reg(3, 32'h0);
        rd_expect(3, 32'h1234, "divisor after zero write");

        // R5: non-key value stored
        phase = "R5";
        wr_reg(8, 32'hAA);
        rd_expect(8, 32'hAA, "key store");

        // R6: transmit pushes
        phase = "R6";
        wr_reg(2, 32'h24);
        wr_reg(0, 32'h31);
        wr_reg(0, 32'h32);
        wr_reg(0, 32'h33);
        rd_expect(4, 32'h10, "flags after push");
        rd_expect(1, 32'h00, "status after push");
        phase = "R13";
        rd_expect(5, 32'd3, "txcnt");

        // R8/R7: short burst drains to empty and raises the interrupt
        phase = "R8";
        burst(5);
        phase = "R7";
        chk(phase, "irq after drain", 32'(irq), 32'd1);
        rd_expect(4, 32'h11, "flags after drain");
        rd_expect(1, 32'h60, "status after drain");
        phase = "R3";
        rd_expect(1, 32'h40, "status cleared by read");
        chk(phase, "irq after clear", 32'(irq), 32'd0);

        // R8: burst limited to BURST bytes
        phase = "R8";
        for (int i = 0; i < 200; i++) wr_reg(0, 32'(i));
        burst(BURST + 4);
        rd_expect(5, 32'd72, "txcnt after one burst");
        line_tx_burst = 1'b1;
        step();
        step();
        line_tx_burst = 1'b0;
        repeat (80) step();
        rd_expect(5, 32'd0, "txcnt after second burst");
        burst(3);
        chk(phase, "no byte from empty queue", 32'(line_tx_valid), 32'd0);

        // R6: full transmit queue drops
        phase = "R6";
        for (int i = 0; i < TXD + 1; i++) wr_reg(0, 32'(i ^ 8'h5A));
        rd_expect(4, 32'h14, "flags after overflow");
        phase = "R13";
        rd_expect(5, 32'(TXD), "txcnt full");
        phase = "R7";
        for (int i = 0; i < TXD / BURST; i++) burst(BURST + 2);
        rd_expect(4, 32'h11, "flags after full drain");

        // R3: status read in the same cycle as the last transmit pop
        phase = "R3";
        rd_expect(1, 32'h60, "status");
        wr_reg(0, 32'h99);
        rd_expect(1, 32'h00, "status before collision");
        line_tx_burst = 1'b1;
        step();
        line_tx_burst = 1'b0;
        rd_expect(1, 32'h00, "status read at pop");
        rd_expect(1, 32'h60, "transmit done kept");

        // R9/R10: receive path
        phase = "R9";
        rx_put(8'hA1);
        rx_put(8'hA2);
        rx_put(8'hA3);
        chk(phase, "irq on receive", 32'(irq), 32'd1);
        rd_expect(4, 32'h01, "flags with rx data");
        phase = "R10";
        rd_expect(0, 32'hA1, "rx byte 1");
        rd_expect(0, 32'hA2, "rx byte 2");
        rd_expect(0, 32'hA3, "rx byte 3");
        rd_expect(4, 32'h11, "flags after rx empty");
        rd_expect(0, 32'h0, "empty read");

        // R3: status read in the same cycle as a receive push
        phase = "R3";
        rd_expect(1, 32'hC0, "status");
        bus_rd = 1'b1; bus_addr = 4'd1;
        line_rx_push = 1'b1; line_rx_byte = 8'h5C;
        step();
        bus_rd = 1'b0; line_rx_push = 1'b0;
        chk(phase, "status read at push", bus_rdata, 32'h40);
        chk(phase, "irq kept by push", 32'(irq), 32'd1);
        rd_expect(1, 32'hC0, "receive event kept");
        rd_expect(0, 32'h5C, "collided byte");

        // R9: full receive queue drops
        phase = "R9";
        for (int i = 0; i < RXD + 1; i++) rx_put(8'(i + 3));
        rd_expect(4, 32'h41, "flags after rx overflow");
        phase = "R13";
        rd_expect(6, 32'(RXD), "rxcnt full");
        phase = "R10";
        for (int i = 0; i < RXD; i++) rd_reg(0, v);
        rd_expect(6, 32'd0, "rxcnt drained");
        rd_expect(4, 32'h51, "flags after rx drain");

        // R4: interrupt gate
        phase = "R4";
        rx_put(8'h11);
        wr_reg(2, 32'h20);
        chk(phase, "irq gated off", 32'(irq), 32'd0);
        wr_reg(2, 32'h24);
        chk(phase, "irq gated on", 32'(irq), 32'd1);
        rd_reg(0, v);

        // R12: sticky receive disable
        phase = "R12";
        wr_reg(2, 32'h04);
        rd_expect(1, 32'hC0, "status");
        rx_put(8'h77);
        rd_expect(6, 32'd0, "rxcnt while disabled");
        rd_expect(1, 32'hC0, "event bit on disabled push");
        wr_reg(2, 32'h24);
        rx_put(8'h78);
        rd_expect(6, 32'd0, "rxcnt still disabled");

        // R5: soft reset
        phase = "R5";
        wr_reg(0, 32'h42);
        wr_reg(3, 32'h00AB);
        wr_reg(8, 32'h55);
        chk(phase, "irq after soft reset", 32'(irq), 32'd0);
        rd_expect(1, 32'h40, "status");
        rd_expect(4, 32'h11, "flags");
        rd_expect(2, 32'h0, "modem");
        rd_expect(3, 32'h0, "divisor");
        rd_expect(8, 32'h0, "key");
        rd_expect(5, 32'd0, "txcnt");
        rd_expect(6, 32'd0, "rxcnt");
        rx_put(8'hE5);
        rd_expect(6, 32'd1, "reception re-enabled");
        rd_expect(0, 32'hE5, "byte after re-enable");

        // Soft reset during a burst
        for (int i = 0; i < 10; i++) wr_reg(0, 32'(i + 100));
        line_tx_burst = 1'b1;
        step();
        line_tx_burst = 1'b0;
        step();
        wr_reg(8, 32'h155);
        chk(phase, "burst aborted", 32'(line_tx_valid), 32'd0);
        repeat (4) step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule